// File: doc/BRIEF.md
# Accumulator-Style 24-bit Processor Core

This block is a small multi-cycle processor for a simple teaching instruction set. Data words are 24 bits wide and stored as three consecutive bytes. The address space is 15 bits, or 32768 bytes. Every instruction is three bytes long and has one format. The first byte is the operation code. The next bit is an index flag. The last 15 bits are an address field. The core runs one instruction at a time and walks a fixed sequence for each one: fetch, decode, operand access, execute.

Memory sits outside the core. The core reaches it through a byte-wide synchronous port. It presents an address in one cycle and takes the read byte in the following cycle. A write happens at the clock edge that ends a cycle in which the write enable is high.

Peripherals use a separate polled port. It carries a device number, a ready input, and one-cycle read and write strobes. The core has no stack. A subroutine call saves the return address in a link register.

If the core decodes an operation code it does not know, it stops. It then raises a halt output and keeps it high until reset.

Top module: `educpu_core`

## Requirements
- R1: Reset has these effects:
  - PC, A, X and L are cleared and the condition code is set to equal.
  - While reset is held, the write enable and the halt output are low.
  - In the first cycle after release, the core presents address 0.
- R2: The core fetches an instruction on three consecutive cycles, from PC, PC+1 and PC+2.
  - The byte at PC is the operation code.
  - Bit 7 of the byte at PC+1 is the index flag.
  - The remaining 15 bits form the address field, most significant bits first.
  - After the fetch, PC has advanced by 3.
- R3: The target address is formed as follows:
  - When the index flag is 0, it is the address field.
  - When the index flag is 1, it is the address field plus X[14:0], modulo 2^15.
- R4: Words in memory are big-endian, with the most significant byte at the target address. The word transfer operations are:
  - 0x00: load A from the word.
  - 0x04: load X from the word.
  - 0x0C: store A to the word.
  - 0x10: store X to the word.
- R5: The arithmetic and logic operations combine A with the memory word and write the 24-bit result to A, wrapping modulo 2^24:
  - 0x18: add.
  - 0x1C: subtract.
  - 0x20: multiply, keeping the low 24 bits of the product.
  - 0x40: bitwise AND.
  - 0x44: bitwise OR.
- R6: Operation 0x24 divides A by the memory word as signed two's-complement values, with the quotient truncated toward zero. A divisor of zero leaves A unchanged.
- R7: Compare and jump:
  - 0x28 compares A with the memory word as signed values and sets the condition code to less, equal or greater.
  - 0x3C loads PC with the target address unconditionally.
  - 0x30 jumps only when the code is equal.
  - 0x34 jumps only when the code is greater.
  - 0x38 jumps only when the code is less.
- R8: Operation 0x2C adds 1 to X. It then compares the new X with the memory word as signed values and sets the condition code.
- R9: Call and return:
  - 0x48 copies the address of the following instruction into L and loads PC with the target address.
  - 0x4C loads PC from L.
- R10: Byte transfers:
  - 0x50 replaces A[7:0] with the byte at the target address and keeps A[23:8].
  - 0x54 writes A[7:0] to the target address only and changes no other byte.
- R11: Device operations use the device number taken from the target address bits [7:0]:
  - 0xE0 tests the device. The condition code becomes less when the device is ready and equal when it is not.
  - 0xD8 issues a one-cycle read strobe and loads the device byte into A[7:0], keeping A[23:8].
  - 0xDC issues a one-cycle write strobe that carries A[7:0].
  - The write enable, the read strobe and the write strobe are never high together.
- R12: Any other operation code stops the core:
  - The halt output goes high and stays high until reset.
  - While halted, the core issues no memory write and no device strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 15 | Byte address presented to memory |
| memRdData | input | 8 | Read byte, valid the cycle after its address |
| memWrData | output | 8 | Byte to be written |
| memWe | output | 1 | Write enable for memAddr |
| devAddr | output | 8 | Device number |
| devReady | input | 1 | Selected device is ready |
| devRdData | input | 8 | Byte supplied by the device during a read strobe |
| devRdStrobe | output | 1 | One-cycle device read |
| devWrStrobe | output | 1 | One-cycle device write |
| devWrData | output | 8 | Byte sent to the device |
| halted | output | 1 | Core stopped on an undefined operation code |

## Verification
The bench builds the core with its default parameter, a reset PC of 0, so every test program starts at address 0.

The bench's memory model is sparse but covers the whole 15-bit space. This makes three cases reachable:
- an indexed target address that wraps past 0x7FFF;
- a counted loop driven by the increment-and-compare operation;
- a call and return through the link register.

Signed compares are exercised with operands on both sides of zero. A device whose ready input rises late makes the test-and-branch polling loop repeat before the read and the write go through.

// File: rtl/educpu_pkg.sv
package educpu_pkg;

  localparam int WORD_W = 24;
  localparam int ADDR_W = 15;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 8;

  localparam logic [7:0] OP_LDA  = 8'h00;
  localparam logic [7:0] OP_LDX  = 8'h04;
  localparam logic [7:0] OP_STA  = 8'h0C;
  localparam logic [7:0] OP_STX  = 8'h10;
  localparam logic [7:0] OP_ADD  = 8'h18;
  localparam logic [7:0] OP_SUB  = 8'h1C;
  localparam logic [7:0] OP_MUL  = 8'h20;
  localparam logic [7:0] OP_DIV  = 8'h24;
  localparam logic [7:0] OP_COMP = 8'h28;
  localparam logic [7:0] OP_TIX  = 8'h2C;
  localparam logic [7:0] OP_JEQ  = 8'h30;
  localparam logic [7:0] OP_JGT  = 8'h34;
  localparam logic [7:0] OP_JLT  = 8'h38;
  localparam logic [7:0] OP_J    = 8'h3C;
  localparam logic [7:0] OP_AND  = 8'h40;
  localparam logic [7:0] OP_OR   = 8'h44;
  localparam logic [7:0] OP_JSUB = 8'h48;
  localparam logic [7:0] OP_RSUB = 8'h4C;
  localparam logic [7:0] OP_LDCH = 8'h50;
  localparam logic [7:0] OP_STCH = 8'h54;
  localparam logic [7:0] OP_RD   = 8'hD8;
  localparam logic [7:0] OP_WD   = 8'hDC;
  localparam logic [7:0] OP_TD   = 8'hE0;

  typedef enum logic [1:0] {
    CC_LT = 2'b00,
    CC_EQ = 2'b01,
    CC_GT = 2'b10
  } ccT;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       addrUseTa;   // address base: target address instead of PC
    logic [1:0] addrOfs;     // byte offset added to the base
    logic       irCap;       // capture fetched byte into the instruction register
    logic       opCap;       // capture read byte into the operand register
    logic [1:0] capIdx;      // byte lane for either capture
    logic       memWe;
    logic [1:0] wrIdx;       // byte lane of a word store
    logic       wrByteOnly;  // single byte store of A[7:0]
    logic       pcInc;
    logic       pcJump;
    logic       pcFromL;
    logic       linkSave;
    logic       exec;        // word operation with the captured operand
    logic       ldch;
    logic       testDev;
    logic       devRd;
    logic       devWr;
  } ctlT;

  function automatic ccT cmpSigned(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    if ($signed(a) < $signed(b))      return CC_LT;
    else if (a == b)                  return CC_EQ;
    else                              return CC_GT;
  endfunction

endpackage

// File: rtl/educpu_control.sv
module educpu_control
  import educpu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] opcode,
  input  ccT         cc,
  output ctlT        ctl,
  output logic       halted
);

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_RDWORD, ST_RDBYTE,
    ST_WRWORD, ST_WRBYTE, ST_EXEC, ST_HALT
  } stateT;

  stateT      state, stateNext;
  logic [1:0] cnt, cntNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_FETCH;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_FETCH: begin
        ctl.addrOfs = cnt;
        ctl.irCap   = (cnt != 2'd0);
        ctl.capIdx  = cnt - 2'd1;
        cntNext     = cnt + 2'd1;
        if (cnt == 2'd3) begin
          ctl.pcInc = 1'b1;
          stateNext = ST_DECODE;
          cntNext   = '0;
        end
      end
      ST_DECODE: begin
        stateNext = ST_FETCH;
        case (opcode)
          OP_LDA, OP_LDX, OP_ADD, OP_SUB, OP_MUL, OP_DIV,
          OP_AND, OP_OR, OP_COMP, OP_TIX: stateNext = ST_RDWORD;
          OP_LDCH:         stateNext = ST_RDBYTE;
          OP_STA, OP_STX:  stateNext = ST_WRWORD;
          OP_STCH:         stateNext = ST_WRBYTE;
          OP_J:            ctl.pcJump = 1'b1;
          OP_JEQ:          ctl.pcJump = (cc == CC_EQ);
          OP_JGT:          ctl.pcJump = (cc == CC_GT);
          OP_JLT:          ctl.pcJump = (cc == CC_LT);
          OP_JSUB: begin
            ctl.linkSave = 1'b1;
            ctl.pcJump   = 1'b1;
          end
          OP_RSUB:         ctl.pcFromL = 1'b1;
          OP_TD:           ctl.testDev = 1'b1;
          OP_RD:           ctl.devRd   = 1'b1;
          OP_WD:           ctl.devWr   = 1'b1;
          default:         stateNext = ST_HALT;
        endcase
      end
      ST_RDWORD: begin
        ctl.addrUseTa = 1'b1;
        ctl.addrOfs   = cnt;
        ctl.opCap     = (cnt != 2'd0);
        ctl.capIdx    = cnt - 2'd1;
        cntNext       = cnt + 2'd1;
        if (cnt == 2'd3) begin
          stateNext = ST_EXEC;
          cntNext   = '0;
        end
      end
      ST_EXEC: begin
        ctl.exec  = 1'b1;
        stateNext = ST_FETCH;
      end
      ST_RDBYTE: begin
        ctl.addrUseTa = 1'b1;
        cntNext       = cnt + 2'd1;
        if (cnt == 2'd1) begin
          ctl.ldch  = 1'b1;
          stateNext = ST_FETCH;
          cntNext   = '0;
        end
      end
      ST_WRWORD: begin
        ctl.addrUseTa = 1'b1;
        ctl.addrOfs   = cnt;
        ctl.memWe     = 1'b1;
        ctl.wrIdx     = cnt;
        cntNext       = cnt + 2'd1;
        if (cnt == 2'd2) begin
          stateNext = ST_FETCH;
          cntNext   = '0;
        end
      end
      ST_WRBYTE: begin
        ctl.addrUseTa  = 1'b1;
        ctl.memWe      = 1'b1;
        ctl.wrByteOnly = 1'b1;
        stateNext      = ST_FETCH;
      end
      ST_HALT: stateNext = ST_HALT;
      default: stateNext = ST_HALT;
    endcase
  end

  assign halted = (state == ST_HALT);

  // R12: once stopped the core stays stopped
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R12: a stopped core touches neither memory nor devices
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !(ctl.memWe || ctl.devRd || ctl.devWr));

  // R11: write enable and device strobes are mutually exclusive
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.memWe, ctl.devRd, ctl.devWr}));

endmodule

// File: rtl/educpu_datapath.sv
module educpu_datapath
  import educpu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [BYTE_W-1:0] memRdData,
  input  logic              devReady,
  input  logic [BYTE_W-1:0] devRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWrData,
  output logic [DEV_W-1:0]  devAddr,
  output logic [BYTE_W-1:0] devWrData,
  output logic [7:0]        opcode,
  output ccT                cc
);

  localparam int INS_W   = WORD_W;
  localparam int XBIT    = ADDR_W;

  logic [WORD_W-1:0] regA, regX, regL, aNext, xNext, lNext;
  logic [ADDR_W-1:0] pc, pcNext, ta;
  logic [INS_W-1:0]  ir;
  logic [WORD_W-1:0] opnd;
  ccT                ccNext;
  logic [WORD_W-1:0] storeWord, prod, xInc;
  logic signed [WORD_W-1:0] quot;

  assign opcode = ir[INS_W-1 -: 8];

  // Target address: field, optionally indexed, wrapping in 15 bits
  assign ta = ir[ADDR_W-1:0] + (ir[XBIT] ? regX[ADDR_W-1:0] : '0);

  assign memAddr   = (ctl.addrUseTa ? ta : pc) + ADDR_W'(ctl.addrOfs);
  assign storeWord = (opcode == OP_STX) ? regX : regA;
  assign memWrData = ctl.wrByteOnly ? regA[BYTE_W-1:0]
                                    : storeWord[WORD_W-1 - BYTE_W*ctl.wrIdx -: BYTE_W];
  assign devAddr   = ta[DEV_W-1:0];
  assign devWrData = regA[BYTE_W-1:0];

  assign prod = regA * opnd;
  assign xInc = regX + 1'b1;
  always_comb begin
    quot = $signed(regA);
    if (opnd != '0) quot = $signed(regA) / $signed(opnd);
  end

  always_comb begin
    aNext  = regA;
    xNext  = regX;
    lNext  = regL;
    pcNext = pc;
    ccNext = cc;
    if (ctl.exec) begin
      case (opcode)
        OP_LDA:  aNext = opnd;
        OP_LDX:  xNext = opnd;
        OP_ADD:  aNext = regA + opnd;
        OP_SUB:  aNext = regA - opnd;
        OP_MUL:  aNext = prod;
        OP_DIV:  aNext = quot;
        OP_AND:  aNext = regA & opnd;
        OP_OR:   aNext = regA | opnd;
        OP_COMP: ccNext = cmpSigned(regA, opnd);
        OP_TIX: begin
          xNext  = xInc;
          ccNext = cmpSigned(xInc, opnd);
        end
        default: ;
      endcase
    end
    if (ctl.ldch)     aNext[BYTE_W-1:0] = memRdData;
    if (ctl.devRd)    aNext[BYTE_W-1:0] = devRdData;
    if (ctl.testDev)  ccNext = devReady ? CC_LT : CC_EQ;
    if (ctl.linkSave) lNext  = WORD_W'(pc);
    if (ctl.pcInc)    pcNext = pc + ADDR_W'(3);
    if (ctl.pcJump)   pcNext = ta;
    if (ctl.pcFromL)  pcNext = regL[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0;
      regX <= '0;
      regL <= '0;
      pc   <= RESET_PC;
      cc   <= CC_EQ;
      ir   <= '0;
      opnd <= '0;
    end else begin
      regA <= aNext;
      regX <= xNext;
      regL <= lNext;
      pc   <= pcNext;
      cc   <= ccNext;
      if (ctl.irCap) ir[INS_W-1 - BYTE_W*ctl.capIdx -: BYTE_W]    <= memRdData;
      if (ctl.opCap) opnd[WORD_W-1 - BYTE_W*ctl.capIdx -: BYTE_W] <= memRdData;
    end
  end

  logic unusedBits;
  assign unusedBits = ^{regL[WORD_W-1:ADDR_W], regX[WORD_W-1:ADDR_W], ctl.memWe, ctl.devWr};

  // R2: a completed fetch advances PC by one instruction
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcInc |=> pc == $past(pc) + ADDR_W'(3));

  // R6: a zero divisor leaves the accumulator alone
  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.exec && opcode == OP_DIV && opnd == '0) |=> regA == $past(regA));

  // R10: byte load keeps the upper accumulator bits
  p_ldch_upper_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldch |=> regA[WORD_W-1:BYTE_W] == $past(regA[WORD_W-1:BYTE_W]));

  // R11: device read keeps the upper accumulator bits
  p_rd_upper_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.devRd |=> regA[WORD_W-1:BYTE_W] == $past(regA[WORD_W-1:BYTE_W]));

  // R9: return lands on the saved link address
  p_rsub_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcFromL |=> pc == $past(regL[ADDR_W-1:0]));

endmodule

// File: rtl/educpu_core.sv
module educpu_core
  import educpu_pkg::*;
#(
  parameter logic [14:0] RESET_PC = 15'h0000
) (
  input  logic        clk,
  input  logic        rstN,
  output logic [14:0] memAddr,
  input  logic [7:0]  memRdData,
  output logic [7:0]  memWrData,
  output logic        memWe,
  output logic [7:0]  devAddr,
  input  logic        devReady,
  input  logic [7:0]  devRdData,
  output logic        devRdStrobe,
  output logic        devWrStrobe,
  output logic [7:0]  devWrData,
  output logic        halted
);

  ctlT        ctl;
  logic [7:0] opcode;
  ccT         cc;

  educpu_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .cc     (cc),
    .ctl    (ctl),
    .halted (halted)
  );

  educpu_datapath #(.RESET_PC(RESET_PC)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .memRdData (memRdData),
    .devReady  (devReady),
    .devRdData (devRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .devAddr   (devAddr),
    .devWrData (devWrData),
    .opcode    (opcode),
    .cc        (cc)
  );

  assign memWe       = ctl.memWe;
  assign devRdStrobe = ctl.devRd;
  assign devWrStrobe = ctl.devWr;

endmodule

// File: tb/test_educpu_core.sv
module test_educpu_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] a;
    logic [23:0] m;
    logic [23:0] exp;
    logic [3:0]  req;
  } vecT;

  localparam vecT VECS [12] = '{
    '{8'h18, 24'h000005, 24'h000007, 24'h00000C, 4'd5},  // R5 add
    '{8'h18, 24'hFFFFFF, 24'h000002, 24'h000001, 4'd5},  // R5 add wrap
    '{8'h1C, 24'h000003, 24'h000005, 24'hFFFFFE, 4'd5},  // R5 sub negative
    '{8'h20, 24'h000003, 24'hFFFFFE, 24'hFFFFFA, 4'd5},  // R5 mul signed
    '{8'h20, 24'h001000, 24'h001000, 24'h000000, 4'd5},  // R5 mul low bits
    '{8'h40, 24'hF0F0F0, 24'h0FF0FF, 24'h00F0F0, 4'd5},  // R5 and
    '{8'h44, 24'h800001, 24'h000100, 24'h800101, 4'd5},  // R5 or
    '{8'h24, 24'h000064, 24'h000007, 24'h00000E, 4'd6},  // R6 divide
    '{8'h24, 24'hFFFFF9, 24'h000002, 24'hFFFFFD, 4'd6},  // R6 truncate toward zero
    '{8'h24, 24'h123456, 24'h000000, 24'h123456, 4'd6},  // R6 divide by zero
    '{8'h00, 24'h111111, 24'h0ABCDE, 24'h0ABCDE, 4'd4},  // R4 load word
    '{8'h50, 24'h123456, 24'hAB0000, 24'h1234AB, 4'd10}  // R10 byte load
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] memAddr;
  logic [7:0]  memRdData = 8'h00;
  logic [7:0]  memWrData;
  logic        memWe;
  logic [7:0]  devAddr;
  logic        devReady = 1'b0;
  logic [7:0]  devRdData = 8'h5A;
  logic        devRdStrobe, devWrStrobe;
  logic [7:0]  devWrData;
  logic        halted;

  logic [7:0] mem [logic [14:0]];

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int rdSeen = 0, wrSeen = 0, weSeen = 0;
  logic [7:0] rdAddr, wrAddr, wrData;

  educpu_core i_educpu_core (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdData(memRdData),
    .memWrData(memWrData), .memWe(memWe), .devAddr(devAddr), .devReady(devReady),
    .devRdData(devRdData), .devRdStrobe(devRdStrobe), .devWrStrobe(devWrStrobe),
    .devWrData(devWrData), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Byte memory with one cycle read latency
  always @(posedge clk) begin
    if (memWe) mem[memAddr] = memWrData;
    memRdData <= mem.exists(memAddr) ? mem[memAddr] : 8'h00;
  end

  always @(negedge clk) begin
    if (devRdStrobe) begin rdSeen++; rdAddr = devAddr; end
    if (devWrStrobe) begin wrSeen++; wrAddr = devAddr; wrData = devWrData; end
    if (memWe) weSeen++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run exceeded %0d cycles (actual hang, expected finish)", WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] peek(input logic [14:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [23:0] peekWord(input logic [14:0] a);
    return {peek(a), peek(a + 15'd1), peek(a + 15'd2)};
  endfunction

  task automatic putWord(input logic [14:0] a, input logic [23:0] w);
    mem[a] = w[23:16];
    mem[a + 15'd1] = w[15:8];
    mem[a + 15'd2] = w[7:0];
  endtask

  task automatic putIns(input logic [14:0] a, input logic [7:0] op,
                        input logic x, input logic [14:0] field);
    putWord(a, {op, x, field});
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runProg(input string req);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rdSeen = 0; wrSeen = 0; weSeen = 0;
    for (int c = 0; c < 5000 && !halted; c++) @(negedge clk);
    check({req, " halt reached"}, 24'(halted), 24'd1);
  endtask

  // LDA 0x100 ; op 0x103 ; STA 0x106 ; halt
  task automatic loadArith(input logic [7:0] op, input logic [23:0] a, input logic [23:0] m);
    mem.delete();
    putIns(15'h000, 8'h00, 1'b0, 15'h100);
    putIns(15'h003, op,    1'b0, 15'h103);
    putIns(15'h006, 8'h0C, 1'b0, 15'h106);
    mem[15'h009] = 8'hFF;
    putWord(15'h100, a);
    putWord(15'h103, m);
  endtask

  // Compare A with M, branch to one of three marker stores
  task automatic loadBranch(input logic [23:0] a, input logic [23:0] m, input logic uncond);
    mem.delete();
    putIns(15'h000, 8'h00, 1'b0, 15'h100);
    if (uncond) putIns(15'h003, 8'h3C, 1'b0, 15'h030);
    else        putIns(15'h003, 8'h28, 1'b0, 15'h103);
    putIns(15'h006, 8'h38, 1'b0, 15'h030);
    putIns(15'h009, 8'h30, 1'b0, 15'h040);
    putIns(15'h00C, 8'h34, 1'b0, 15'h050);
    mem[15'h00F] = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      putIns(15'h030 + 15'(16*k), 8'h00, 1'b0, 15'h130 + 15'(16*k));
      putIns(15'h033 + 15'(16*k), 8'h0C, 1'b0, 15'h106);
      mem[15'h036 + 15'(16*k)] = 8'hFF;
      putWord(15'h130 + 15'(16*k), 24'(k + 1));
    end
    putWord(15'h100, a);
    putWord(15'h103, m);
  endtask

  initial begin
    // R1: reset state and first fetch address; R2 fetch order
    mem.delete();
    repeat (2) @(negedge clk);
    check("R1 memWe in reset", 24'(memWe), 24'd0);
    check("R1 halted in reset", 24'(halted), 24'd0);
    rstN = 1'b1;
    #1;
    check("R1 first address", 24'(memAddr), 24'h0);
    @(negedge clk);
    check("R2 second fetch byte address", 24'(memAddr), 24'h1);
    @(negedge clk);
    check("R2 third fetch byte address", 24'(memAddr), 24'h2);

    // Table of word operations (R4 R5 R6 R10)
    for (int i = 0; i < 12; i++) begin
      loadArith(VECS[i].op, VECS[i].a, VECS[i].m);
      runProg($sformatf("R%0d vector %0d", VECS[i].req, i));
      check($sformatf("R%0d vector %0d op %h", VECS[i].req, i, VECS[i].op),
            peekWord(15'h106), VECS[i].exp);
    end

    // R3: indexed address wraps modulo 2^15 (0x7F00 + 0x200 -> 0x0100)
    mem.delete();
    putIns(15'h000, 8'h04, 1'b0, 15'h200);
    putIns(15'h003, 8'h00, 1'b1, 15'h7F00);
    putIns(15'h006, 8'h0C, 1'b0, 15'h110);
    mem[15'h009] = 8'hFF;
    putWord(15'h200, 24'h000200);
    putWord(15'h100, 24'h654321);
    runProg("R3");
    check("R3 indexed wrap load", peekWord(15'h110), 24'h654321);

    // R4: store X, big-endian
    mem.delete();
    putIns(15'h000, 8'h04, 1'b0, 15'h200);
    putIns(15'h003, 8'h10, 1'b0, 15'h120);
    mem[15'h006] = 8'hFF;
    putWord(15'h200, 24'hA1B2C3);
    runProg("R4");
    check("R4 STX first byte", 24'(peek(15'h120)), 24'hA1);
    check("R4 STX word", peekWord(15'h120), 24'hA1B2C3);

    // R7: signed compare and conditional jumps, then unconditional jump
    loadBranch(24'hFFFFFF, 24'h000001, 1'b0);
    runProg("R7");
    check("R7 less (signed) takes JLT", peekWord(15'h106), 24'd1);
    loadBranch(24'h000005, 24'h000005, 1'b0);
    runProg("R7");
    check("R7 equal takes JEQ", peekWord(15'h106), 24'd2);
    loadBranch(24'h000001, 24'hFFFFFF, 1'b0);
    runProg("R7");
    check("R7 greater takes JGT", peekWord(15'h106), 24'd3);
    loadBranch(24'h000000, 24'h000000, 1'b1);
    runProg("R7");
    check("R7 unconditional jump", peekWord(15'h106), 24'd1);

    // R8: counted loop with increment-and-compare
    mem.delete();
    putIns(15'h000, 8'h04, 1'b0, 15'h200);
    putIns(15'h003, 8'h2C, 1'b0, 15'h203);
    putIns(15'h006, 8'h38, 1'b0, 15'h003);
    putIns(15'h009, 8'h10, 1'b0, 15'h210);
    mem[15'h00C] = 8'hFF;
    putWord(15'h200, 24'h000000);
    putWord(15'h203, 24'h000003);
    runProg("R8");
    check("R8 loop count", peekWord(15'h210), 24'h000003);

    // R9: call then return to the following instruction
    mem.delete();
    putIns(15'h000, 8'h48, 1'b0, 15'h040);
    putIns(15'h003, 8'h0C, 1'b0, 15'h106);
    mem[15'h006] = 8'hFF;
    putIns(15'h040, 8'h00, 1'b0, 15'h100);
    putIns(15'h043, 8'h4C, 1'b0, 15'h000);
    putWord(15'h100, 24'h0F0F0F);
    runProg("R9");
    check("R9 call/return", peekWord(15'h106), 24'h0F0F0F);

    // R10: single byte store leaves neighbours alone
    mem.delete();
    putIns(15'h000, 8'h00, 1'b0, 15'h100);
    putIns(15'h003, 8'h54, 1'b0, 15'h121);
    mem[15'h006] = 8'hFF;
    putWord(15'h100, 24'h1234CD);
    putWord(15'h120, 24'h112233);
    runProg("R10");
    check("R10 STCH target byte", 24'(peek(15'h121)), 24'hCD);
    check("R10 STCH lower neighbour", 24'(peek(15'h120)), 24'h11);
    check("R10 STCH upper neighbour", 24'(peek(15'h122)), 24'h33);

    // R11: poll until ready, read device 5, write device 6
    mem.delete();
    putIns(15'h000, 8'h00, 1'b0, 15'h100);
    putIns(15'h003, 8'hE0, 1'b0, 15'h005);
    putIns(15'h006, 8'h30, 1'b0, 15'h003);
    putIns(15'h009, 8'hD8, 1'b0, 15'h005);
    putIns(15'h00C, 8'hDC, 1'b0, 15'h006);
    putIns(15'h00F, 8'h0C, 1'b0, 15'h106);
    mem[15'h012] = 8'hFF;
    putWord(15'h100, 24'hABCD00);
    devReady = 1'b0;
    fork
      begin repeat (60) @(negedge clk); devReady = 1'b1; end
    join_none
    runProg("R11");
    check("R11 stored A after read", peekWord(15'h106), 24'hABCD5A);
    check("R11 read strobes", 24'(rdSeen), 24'd1);
    check("R11 write strobes", 24'(wrSeen), 24'd1);
    check("R11 read device", 24'(rdAddr), 24'h05);
    check("R11 write device", 24'(wrAddr), 24'h06);
    check("R11 write data", 24'(wrData), 24'h5A);

    // R12: halted core stays halted and quiet
    weSeen = 0; rdSeen = 0; wrSeen = 0;
    repeat (20) @(negedge clk);
    check("R12 halted persists", 24'(halted), 24'd1);
    check("R12 no activity while halted", 24'(weSeen + rdSeen + wrSeen), 24'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule